// File: doc/BRIEF.md
# Three-Phase Elliptical Reference Generator

This block produces the three modulating references for a multilevel PWM stage. It does not use a sine shape. Each half period is half of an ellipse, so the waveform stays close to its peak for longer and rises steeply through zero. A constant 1024-entry table holds one full period of this shape and is read through a two-stage counter. With a 40 MHz clock and the default prescaler, one sweep of the table lasts about 20 ms (50 Hz).

Phase A reads the table at the current step index. Phases B and C read the same table one third and two thirds of a period further on. Each sample is multiplied by an unsigned modulation index and saturated to the signed output range. Every time the step index advances, the three new words appear together with a one-cycle strobe. Enable freezes and resumes the sweep. Synchronous reset restarts the sweep at index 0.

Top module: `ellip_ref_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `ph_a`, `ph_b` and `ph_c` become 0 and `smp_valid` becomes 0. The prescaler and the step index are cleared, so the first strobe after reset carries step index 0.
- R2: With `en` held high, `smp_valid` is high for exactly one cycle once every PRESC_MAX+1 clock cycles (783 by default).
- R3: The k-th strobe since reset carries, on `ph_a`, the table word at index k mod 1024. After index 1023 the sweep returns to 0.
- R4: At the same strobe, `ph_b` carries the table word at index (k+341) mod 1024 and `ph_c` carries the word at (k+683) mod 1024.
- R5: Table word i (FS = 32767, H = 512) is built as follows. Let j = i mod H, x = 2j+1-H and s = floor(sqrt(H*H - x*x)). The word is floor(FS*s/H) for i < H and the negative of that value otherwise.
- R6: Each output equals floor(w*m / 32768), where w is the table word and m is `mod_idx` read as unsigned Q1.15. The value 0x8000 is unity gain and 0x0000 gives zero.
- R7: A scaled result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R8: While `en` is low, the sweep holds its position, no strobe appears and the outputs keep their values. Raising `en` again continues with the next step index.
- R9: Suppose `en` is first seen high at a rising edge E while the prescaler is at 0. Then the new words and `smp_valid` appear at the fourth rising edge after E, not at any earlier edge.
- R10: The three outputs change only at the edge that raises `smp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advances the prescaler when high |
| mod_idx | input | 16 | Modulation index, unsigned Q1.15 |
| ph_a | output | 16 | Phase A reference, signed |
| ph_b | output | 16 | Phase B reference, signed |
| ph_c | output | 16 | Phase C reference, signed |
| smp_valid | output | 1 | One-cycle strobe for a new sample set |

## Verification
A sample set is due at the fourth rising edge after the edge where the step starts. Before that, the table is read for the three phases in consecutive cycles, and each read passes through the table register and the scaling register. The bench measures that latency cycle by cycle once. After that, it checks strobe spacing by counting cycles between strobes. Expected triplets are queued in step order with the modulation index held constant, and the index changes only in the cycle after a strobe, well before the next table read. So every comparison happens at the strobe that carries that triplet, and the scaling input is never ambiguous.

// File: rtl/ellip_ref_pkg.sv
package ellip_ref_pkg;

  // Integer square root by the digit-by-digit method, 16 result bits.
  function automatic int isqrt(input int n);
    int rem;
    int root;
    int bitv;
    rem  = n;
    root = 0;
    bitv = 32'h4000_0000;
    for (int i = 0; i < 16; i++) begin
      if (rem >= root + bitv) begin
        rem  = rem - (root + bitv);
        root = (root >> 1) + bitv;
      end else begin
        root = root >> 1;
      end
      bitv = bitv >> 2;
    end
    return root;
  endfunction

  // One period of half-ellipses: positive lobe, then negative lobe.
  function automatic int ellip_word(input int idx, input int depth, input int fs);
    int half;
    int j;
    int x;
    int s;
    int v;
    half = depth / 2;
    j    = idx % half;
    x    = 2 * j + 1 - half;
    s    = isqrt(half * half - x * x);
    v    = (fs * s) / half;
    return (idx < half) ? v : -v;
  endfunction

endpackage

// File: rtl/ref_step_counter.sv
module ref_step_counter #(
  parameter int PRESC_MAX = 782,
  parameter int ADDR_W    = 10,
  localparam int PW       = $clog2(PRESC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [PW-1:0]     presc_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              start,
  output logic              adv
);

  localparam logic [PW-1:0] LAST = PW'(PRESC_MAX);

  assign start = en && (presc_q == '0);
  assign adv   = en && (presc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      addr_q  <= '0;
    end else if (en) begin
      if (presc_q == LAST) begin
        presc_q <= '0;
        addr_q  <= addr_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ellip_rom.sv
module ellip_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int FS    = (1 << (DATA_W - 1)) - 1
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] rd_q
);

  logic signed [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(ellip_ref_pkg::ellip_word(i, DEPTH, FS));
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
  end

endmodule

// File: rtl/ref_scaler.sv
module ref_scaler #(
  parameter int DATA_W  = 16,
  parameter int MI_W    = 16,
  parameter int MI_FRAC = 15,
  localparam int PW     = DATA_W + MI_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] smp,
  input  logic [MI_W-1:0]          mi,
  output logic signed [DATA_W-1:0] res_q
);

  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    prod    = smp * $signed({1'b0, mi});
    shifted = prod >>> MI_FRAC;
    if (shifted > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (shifted < MINV) sat = MINV[DATA_W-1:0];
    else                     sat = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= sat;
  end

endmodule

// File: rtl/ellip_ref_gen.sv
module ellip_ref_gen #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int MI_W      = 16,
  parameter int MI_FRAC   = 15,
  parameter int PRESC_MAX = 782
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [MI_W-1:0]          mod_idx,
  output logic signed [DATA_W-1:0] ph_a,
  output logic signed [DATA_W-1:0] ph_b,
  output logic signed [DATA_W-1:0] ph_c,
  output logic                     smp_valid
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(PRESC_MAX + 1);
  localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'((DEPTH + 1) / 3);
  localparam logic [ADDR_W-1:0] OFS_C = ADDR_W'((2 * DEPTH + 1) / 3);

  // The three phase reads share one table port and need three cycles per step.
  generate
    if (PRESC_MAX < 2) begin : g_bad_presc
      $error("PRESC_MAX must be at least 2");
    end
  endgenerate

  logic [PW-1:0]            presc_q;
  logic [ADDR_W-1:0]        step_addr;
  logic                     step_start;
  logic                     step_adv;
  logic [1:0]               iss_q;
  logic [2:0]               lane_now;
  logic [2:0]               tag1_q;
  logic [2:0]               tag2_q;
  logic [ADDR_W-1:0]        rd_addr;
  logic signed [DATA_W-1:0] rom_q;
  logic signed [DATA_W-1:0] scl_q;
  logic signed [DATA_W-1:0] stg_a_q;
  logic signed [DATA_W-1:0] stg_b_q;

  ref_step_counter #(
    .PRESC_MAX (PRESC_MAX),
    .ADDR_W    (ADDR_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .presc_q (presc_q),
    .addr_q  (step_addr),
    .start   (step_start),
    .adv     (step_adv)
  );

  // Read issue: phase A in the start cycle, B and C in the two cycles after.
  assign lane_now = {iss_q[1], iss_q[0], step_start};

  always_comb begin
    if (iss_q[0])      rd_addr = step_addr + OFS_B;
    else if (iss_q[1]) rd_addr = step_addr + OFS_C;
    else               rd_addr = step_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_q  <= '0;
      tag1_q <= '0;
      tag2_q <= '0;
    end else begin
      iss_q  <= {iss_q[0], step_start};
      tag1_q <= lane_now;
      tag2_q <= tag1_q;
    end
  end

  ellip_rom #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rom (
    .clk  (clk),
    .addr (rd_addr),
    .rd_q (rom_q)
  );

  ref_scaler #(
    .DATA_W  (DATA_W),
    .MI_W    (MI_W),
    .MI_FRAC (MI_FRAC)
  ) u_scl (
    .clk   (clk),
    .rst   (rst),
    .smp   (rom_q),
    .mi    (mod_idx),
    .res_q (scl_q)
  );

  // Collect A and B, then publish all three words with the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_a_q   <= '0;
      stg_b_q   <= '0;
      ph_a      <= '0;
      ph_b      <= '0;
      ph_c      <= '0;
      smp_valid <= 1'b0;
    end else begin
      if (tag2_q[0]) stg_a_q <= scl_q;
      if (tag2_q[1]) stg_b_q <= scl_q;
      if (tag2_q[2]) begin
        ph_a <= stg_a_q;
        ph_b <= stg_b_q;
        ph_c <= scl_q;
      end
      smp_valid <= tag2_q[2];
    end
  end

endmodule

// File: rtl/ellip_ref_chk.sv
module ellip_ref_chk #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int PRESC_MAX = 782,
  parameter int PW        = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              valid,
  input logic [DATA_W-1:0] ph_a,
  input logic [DATA_W-1:0] ph_b,
  input logic [DATA_W-1:0] ph_c,
  input logic [PW-1:0]     presc,
  input logic [ADDR_W-1:0] addr,
  input logic              adv
);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R2
  presc_range_chk: assert property (@(posedge clk) disable iff (rst)
    presc <= PW'(PRESC_MAX));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(presc) && $stable(addr)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(ph_a) && $stable(ph_b) && $stable(ph_c)));

endmodule

bind ellip_ref_gen ellip_ref_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PRESC_MAX (PRESC_MAX),
  .PW        ($clog2(PRESC_MAX + 1))
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .valid (smp_valid),
  .ph_a  (ph_a),
  .ph_b  (ph_b),
  .ph_c  (ph_c),
  .presc (presc_q),
  .addr  (step_addr),
  .adv   (step_adv)
);

// File: tb/tb_ellip_ref_gen.sv
module tb_ellip_ref_gen;

  localparam int P     = 7;
  localparam int STEP  = P + 1;
  localparam int DEPTH = 1024;

  typedef struct {
    int    idx;
    int    a;
    int    b;
    int    c;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] mod_idx = 16'h8000;
  logic signed [15:0] ph_a, ph_b, ph_c;
  logic        smp_valid;

  int checks = 0;
  int errors = 0;
  int next_idx = 0;
  int cyc = 0;
  int last_vcyc = 0;
  int last_gap = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  ellip_ref_gen #(.PRESC_MAX(P)) dut (
    .clk(clk), .rst(rst), .en(en), .mod_idx(mod_idx),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .smp_valid(smp_valid)
  );

  function automatic int tbl(input int k);
    int j, x, s, v;
    j = k % 512;
    x = 2 * j + 1 - 512;
    s = int'($floor($sqrt(real'(262144 - x * x))));
    v = (32767 * s) / 512;
    return (k < 512) ? v : -v;
  endfunction

  function automatic int scl(input int s, input int m);
    longint p;
    p = longint'(s) * longint'(m);
    p = p >>> 15;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_items(input int n, input int m, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.idx = next_idx;
      e.a   = scl(tbl(next_idx), m);
      e.b   = scl(tbl((next_idx + 341) % DEPTH), m);
      e.c   = scl(tbl((next_idx + 683) % DEPTH), m);
      e.req = req;
      q.push_back(e);
      next_idx = (next_idx + 1) % DEPTH;
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) cyc++;

  // Monitor: compare each strobe with the oldest expected triplet.
  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      last_gap  = cyc - last_vcyc;
      last_vcyc = cyc;
      if (q.size() == 0) begin
        check("R8", "strobe with nothing expected", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check((e.req == "R3") ? "R3" : e.req, $sformatf("ph_a idx %0d", e.idx), int'(ph_a), e.a);
        check((e.req == "R3") ? "R4" : e.req, $sformatf("ph_b idx %0d", e.idx), int'(ph_b), e.b);
        check((e.req == "R3") ? "R4" : e.req, $sformatf("ph_c idx %0d", e.idx), int'(ph_c), e.c);
      end
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("WD", "watchdog expired", 1, 0);
    finish_sim();
  end

  initial begin
    logic signed [15:0] ha, hb, hc;
    // R1: reset state
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", "valid in reset", int'(smp_valid), 0);
    check("R1", "ph_a in reset", int'(ph_a), 0);
    check("R1", "ph_b in reset", int'(ph_b), 0);
    check("R1", "ph_c in reset", int'(ph_c), 0);
    rst = 1'b0;
    // R8: idle with enable low
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "valid while disabled", int'(smp_valid), 0);

    // R9: latency from the first enabled edge
    push_items(1, 32'h8000, "R3");
    en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9", "valid too early", int'(smp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check("R9", "valid at fourth edge after start", int'(smp_valid), 1);

    // R3 R4 R5: full sweep with wrap at unity gain
    push_items(1100, 32'h8000, "R3");
    drain();
    // R2: strobe spacing
    check("R2", "cycles between strobes", last_gap, STEP);

    // R6: other gains
    mod_idx = 16'h4000;
    push_items(300, 32'h4000, "R6");
    drain();
    mod_idx = 16'h0000;
    push_items(20, 32'h0000, "R6");
    drain();
    mod_idx = 16'h6ccd;
    push_items(80, 32'h6ccd, "R6");
    drain();

    // R7: saturation at the largest index
    mod_idx = 16'hffff;
    push_items(600, 32'hffff, "R7");
    drain();

    // R8 R10: enable low holds everything
    en = 1'b0;
    ha = ph_a; hb = ph_b; hc = ph_c;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R8", "ph_a held", int'(ph_a), int'(ha));
    check("R10", "ph_b held", int'(ph_b), int'(hb));
    check("R10", "ph_c held", int'(ph_c), int'(hc));
    check("R8", "valid while disabled", int'(smp_valid), 0);
    mod_idx = 16'h8000;
    push_items(5, 32'h8000, "R8");
    en = 1'b1;
    drain();

    // R1: reset in the middle of a sweep restarts at index 0
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "ph_a after mid-run reset", int'(ph_a), 0);
    check("R1", "valid after mid-run reset", int'(smp_valid), 0);
    next_idx = 0;
    push_items(3, 32'h8000, "R1");
    rst = 1'b0;
    drain();

    finish_sim();
  end

endmodule